// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Alarm

This block keeps low-rate time inside a single clock domain. It does not take the slow clocks as clocks. Each slow source arrives as a one-cycle strobe on the system clock `clk`. One source is chosen: an external 32.768 kHz oscillator, an internal slow oscillator of about 32 kHz, or `clk` itself divided by a fixed factor of 128. The chosen strobe feeds a 20-bit reloading prescaler. Each time the prescaler expires it issues a time-base tick, and every tick advances a free-running 32-bit counter.

The counter is compared with an alarm value. Three sticky flags record events: a tick, an alarm match and a counter wrap. Each flag has its own interrupt enable and its own interrupt output. A square-wave calibration output runs at 1/64 of the external strobe rate, which is 512 Hz when the external strobe is at 32.768 kHz. Software reaches the block through a simple register port with a write strobe and a combinational read. The reload, counter and alarm registers accept writes only while the configuration-enable bit is set.

Top module: `rtc_timebase`

## Requirements
- R1: After reset the reload value reads 32767, so the tick period is one second at 32.768 kHz. After reset the counter reads 0, the alarm reads 0xFFFFFFFF, and the control, flags, interrupts and `cal_o` are all 0.
- R2: The control field ctrl[5:4] picks the strobe: 0 selects `ext_stb`, 1 selects `int_stb`, and 2 or 3 selects one pulse every 128 `clk` cycles. Strobes from unselected sources do not advance the counter.
- R3: The prescaler gives one tick for every reload+1 selected strobes. A write of the reload register (address 1) also restarts the prescaler count from the new value.
- R4: Each tick raises the counter by exactly 1, and the counter is visible on `count_o` and at address 2. Each tick also sets the tick flag, flags bit 0.
- R5: A tick at 0xFFFFFFFF wraps the counter to 0 and sets the overflow flag, flags bit 2.
- R6: A tick that brings the counter to the alarm value (address 3) sets the alarm flag, flags bit 1.
- R7: Writes to address 1, 2 or 3 have no effect unless ctrl bit 0 (configuration enable) is set. Writes to the control register (address 0) are always accepted.
- R8: Flags (address 4) stay set until software writes a 1 to that bit at address 4. `irq_tick`, `irq_alarm` and `irq_ovf` are each flag ANDed with its enable: ctrl bit 1, bit 2 and bit 3 in that order.
- R9: `cal_o` toggles after every 32 `ext_stb` pulses, whatever the source selection, so its period is 64 external strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_stb | input | 1 | External slow-oscillator strobe |
| int_stb | input | 1 | Internal slow-oscillator strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational |
| count_o | output | 32 | Current counter value |
| irq_tick | output | 1 | Tick interrupt |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_ovf | output | 1 | Overflow interrupt |
| cal_o | output | 1 | Calibration square wave |

## Verification
The counter is driven with hand-timed external strobes under a short reload. This shows whether ticks arrive after exactly reload+1 strobes and whether the alarm and wrap flags fire on the right increment. Strobes on the unselected source, mixed with strobes on the selected internal one, separate a correct source mux from one that ORs or swaps the inputs. A free-running window on the divided fast clock checks the 128-cycle divider against the time the counter takes to advance. Writes made while configuration is locked must leave both the readback and the counter stream unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [1:0] {
      SRC_EXT   = 2'd0,
      SRC_INT   = 2'd1,
      SRC_FAST  = 2'd2,
      SRC_FAST2 = 2'd3
   } rtc_src_e;

   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_RELOAD = 3'd1;
   localparam logic [2:0] A_COUNT  = 3'd2;
   localparam logic [2:0] A_ALARM  = 3'd3;
   localparam logic [2:0] A_FLAGS  = 3'd4;

   localparam int F_TICK  = 0;
   localparam int F_ALARM = 1;
   localparam int F_OVF   = 2;
   localparam int N_FLAGS = 3;

   localparam int CTRL_W = 6;
endpackage

// File: rtl/rtc_src_sel.sv
module rtc_src_sel
   import rtc_pkg::*;
#(
   parameter int FAST_DIV = 128,
   parameter int CAL_HALF = 32
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ext_stb,
   input  logic     int_stb,
   input  rtc_src_e sel,
   output logic     tb_stb,
   output logic     cal_o
);
   localparam int DIV_W = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1;
   localparam int CAL_W = (CAL_HALF > 2) ? $clog2(CAL_HALF) : 1;

   logic [DIV_W-1:0] div_q;
   logic             fast_stb;
   logic [CAL_W-1:0] cal_cnt_q;

   generate
      if ((FAST_DIV & (FAST_DIV - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_q <= '0;
            else        div_q <= div_q + 1'b1;
         end
         assign fast_stb = &div_q;
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                div_q <= '0;
            else if (div_q == DIV_W'(FAST_DIV - 1))    div_q <= '0;
            else                                       div_q <= div_q + 1'b1;
         end
         assign fast_stb = (div_q == DIV_W'(FAST_DIV - 1));
      end
   endgenerate

   always_comb begin
      case (sel)
         SRC_EXT: tb_stb = ext_stb;
         SRC_INT: tb_stb = int_stb;
         default: tb_stb = fast_stb;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_cnt_q <= '0;
         cal_o     <= 1'b0;
      end else if (ext_stb) begin
         if (cal_cnt_q == CAL_W'(CAL_HALF - 1)) begin
            cal_cnt_q <= '0;
            cal_o     <= ~cal_o;
         end else begin
            cal_cnt_q <= cal_cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int W            = 20,
   parameter int RESET_RELOAD = 32767
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] reload,
   output logic         tick
);
   logic [W-1:0] cnt_q;

   assign tick = stb && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload <= W'(RESET_RELOAD);
         cnt_q  <= W'(RESET_RELOAD);
      end else if (load) begin
         reload <= load_val;
         cnt_q  <= load_val;
      end else if (stb) begin
         cnt_q  <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr_cnt,
   input  logic         wr_alarm,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] count,
   output logic [W-1:0] alarm,
   output logic         alarm_hit,
   output logic         wrap
);
   logic [W-1:0] nxt;
   logic         step;

   assign step      = tick && !wr_cnt;
   assign nxt       = count + 1'b1;
   assign wrap      = step && (&count);
   assign alarm_hit = step && (nxt == alarm);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (wr_cnt) count <= wdata;
      else if (step)   count <= nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        alarm <= '1;
      else if (wr_alarm) alarm <= wdata;
   end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
   import rtc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int PRESC_W      = 20,
   parameter int CNT_W        = 32,
   parameter int RESET_RELOAD = 32767,
   parameter int FAST_DIV     = 128,
   parameter int CAL_HALF     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_stb,
   input  logic              int_stb,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count_o,
   output logic              irq_tick,
   output logic              irq_alarm,
   output logic              irq_ovf,
   output logic              cal_o
);
   generate
      if (PRESC_W > DATA_W || CNT_W > DATA_W) begin : g_bad_width
         $error("rtc_timebase: register wider than data bus");
      end
      if (PRESC_W < 31 && RESET_RELOAD >= (1 << PRESC_W)) begin : g_bad_reload
         $error("rtc_timebase: reset reload does not fit prescaler");
      end
      if (FAST_DIV < 2 || CAL_HALF < 2) begin : g_bad_div
         $error("rtc_timebase: divider parameters must be at least 2");
      end
   endgenerate

   logic [CTRL_W-1:0]  ctrl_q;
   logic [N_FLAGS-1:0] flags_q;
   logic [N_FLAGS-1:0] flag_set;
   logic               cfg_en;
   logic               wr_reload, wr_cnt, wr_alarm, wr_clr;
   logic               tb_stb, tick, alarm_hit, wrap;
   logic [PRESC_W-1:0] reload;
   logic [CNT_W-1:0]   alarm;
   rtc_src_e           src;

   assign cfg_en    = ctrl_q[0];
   assign src       = rtc_src_e'(ctrl_q[5:4]);
   assign wr_reload = wr_en && (wr_addr == A_RELOAD) && cfg_en;
   assign wr_cnt    = wr_en && (wr_addr == A_COUNT)  && cfg_en;
   assign wr_alarm  = wr_en && (wr_addr == A_ALARM)  && cfg_en;
   assign wr_clr    = wr_en && (wr_addr == A_FLAGS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ctrl_q <= '0;
      else if (wr_en && wr_addr == A_CTRL)     ctrl_q <= wr_data[CTRL_W-1:0];
   end

   rtc_src_sel #(.FAST_DIV(FAST_DIV), .CAL_HALF(CAL_HALF)) u_src (
      .clk(clk), .rst_n(rst_n), .ext_stb(ext_stb), .int_stb(int_stb),
      .sel(src), .tb_stb(tb_stb), .cal_o(cal_o)
   );

   rtc_prescaler #(.W(PRESC_W), .RESET_RELOAD(RESET_RELOAD)) u_presc (
      .clk(clk), .rst_n(rst_n), .stb(tb_stb), .load(wr_reload),
      .load_val(wr_data[PRESC_W-1:0]), .reload(reload), .tick(tick)
   );

   rtc_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_cnt(wr_cnt),
      .wr_alarm(wr_alarm), .wdata(wr_data[CNT_W-1:0]), .count(count_o),
      .alarm(alarm), .alarm_hit(alarm_hit), .wrap(wrap)
   );

   always_comb begin
      flag_set          = '0;
      flag_set[F_TICK]  = tick;
      flag_set[F_ALARM] = alarm_hit;
      flag_set[F_OVF]   = wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags_q <= '0;
      else if (wr_clr) flags_q <= (flags_q & ~wr_data[N_FLAGS-1:0]) | flag_set;
      else             flags_q <= flags_q | flag_set;
   end

   assign irq_tick  = flags_q[F_TICK]  & ctrl_q[1];
   assign irq_alarm = flags_q[F_ALARM] & ctrl_q[2];
   assign irq_ovf   = flags_q[F_OVF]   & ctrl_q[3];

   always_comb begin
      case (rd_addr)
         A_CTRL:   rd_data = DATA_W'(ctrl_q);
         A_RELOAD: rd_data = DATA_W'(reload);
         A_COUNT:  rd_data = DATA_W'(count_o);
         A_ALARM:  rd_data = DATA_W'(alarm);
         A_FLAGS:  rd_data = DATA_W'(flags_q);
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic             cnt_wr,
   input logic             raw_cnt_wr,
   input logic             cfg_en,
   input logic             clr_wr,
   input logic [2:0]       clr_bits,
   input logic [2:0]       flags
);
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count) && !$past(cnt_wr)) |-> count == $past(count) + 1'b1); // R4

   AST_TICK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count) && !$past(cnt_wr)) |-> flags[0]); // R4

   AST_WRAP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      ((&$past(count)) && count == '0 && !$past(cnt_wr)) |-> flags[2]); // R5

   AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(raw_cnt_wr) && !$past(cfg_en)) |->
         (count == $past(count) || count == $past(count) + 1'b1)); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flags[1]) && !flags[1]) |-> ($past(clr_wr) && $past(clr_bits[1]))); // R8
endmodule

bind rtc_timebase rtc_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .count(count_o), .cnt_wr(wr_cnt),
   .raw_cnt_wr(wr_en && wr_addr == 3'd2), .cfg_en(cfg_en),
   .clr_wr(wr_clr), .clr_bits(wr_data[2:0]), .flags(flags_q)
);

// File: tb/rtc_timebase_test.sv
module rtc_timebase_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_stb = 1'b0, int_stb = 1'b0, wr_en = 1'b0;
   logic [2:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data, count_o;
   logic        irq_tick, irq_alarm, irq_ovf, cal_o;

   int checks = 0, failures = 0;
   logic [31:0] expq[$];
   logic [31:0] m_cnt = 0, m_reload = 32767, m_pcnt = 32767;
   bit          m_cfg = 0;
   int          ext_total = 0;
   logic [31:0] prev_cnt = 0;
   bit          done = 0;

   always #2.5 clk = ~clk;

   rtc_timebase uut (
      .clk(clk), .rst_n(rst_n), .ext_stb(ext_stb), .int_stb(int_stb),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .count_o(count_o), .irq_tick(irq_tick),
      .irq_alarm(irq_alarm), .irq_ovf(irq_ovf), .cal_o(cal_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: every change of count_o must match the next expected item
   always @(negedge clk) begin
      if (rst_n && count_o !== prev_cnt) begin
         if (expq.size() == 0) check("R7 unexpected count change", count_o, prev_cnt);
         else check("R4 count stream", count_o, expq.pop_front());
         prev_cnt = count_o;
      end
   end

   // model of one selected strobe (R3)
   task automatic model_stb();
      if (m_pcnt == 0) begin
         m_cnt = m_cnt + 1;
         expq.push_back(m_cnt);
         m_pcnt = m_reload;
      end else m_pcnt = m_pcnt - 1;
   endtask

   task automatic pulse(input bit ext, input bit counts);
      @(negedge clk);
      if (counts) model_stb();
      if (ext) begin ext_stb = 1'b1; ext_total++; end
      else int_stb = 1'b1;
      @(negedge clk);
      ext_stb = 1'b0; int_stb = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      if (m_cfg && a == 3'd2) begin m_cnt = d; expq.push_back(d); end
      if (m_cfg && a == 3'd1) begin m_reload = d; m_pcnt = d; end
      if (a == 3'd0) m_cfg = d[0];
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   initial begin
      #(5ns * 150000);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(3'd1, d); check("R1 reload", d, 32'd32767);
      rd(3'd3, d); check("R1 alarm", d, 32'hFFFF_FFFF);
      rd(3'd0, d); check("R1 ctrl", d, 0);
      rd(3'd4, d); check("R1 flags", d, 0);
      check("R1 count", count_o, 0);
      check("R1 irqs/cal", {irq_tick, irq_alarm, irq_ovf, cal_o}, 0);
      // R7 locked writes
      wr(3'd1, 32'd2); wr(3'd2, 32'd100); wr(3'd3, 32'd9);
      rd(3'd1, d); check("R7 reload locked", d, 32'd32767);
      rd(3'd3, d); check("R7 alarm locked", d, 32'hFFFF_FFFF);
      // unlock, all irq enables, external source
      wr(3'd0, 32'h0F);
      wr(3'd1, 32'd2); wr(3'd3, 32'd2);
      for (int i = 0; i < 5; i++) pulse(1, 1);
      rd(3'd4, d); check("R3 tick after reload+1 strobes", d, 32'h1);
      pulse(1, 1);
      rd(3'd4, d); check("R6 alarm flag", d, 32'h3);
      check("R8 irqs", {irq_tick, irq_alarm, irq_ovf}, 3'b110);
      check("R4 count", count_o, 2);
      wr(3'd4, 32'h7);
      rd(3'd4, d); check("R8 clear", d, 0);
      check("R8 irqs cleared", {irq_tick, irq_alarm, irq_ovf}, 3'b000);
      // tick irq disabled
      wr(3'd0, 32'h0D);
      for (int i = 0; i < 3; i++) pulse(1, 1);
      rd(3'd4, d); check("R8 flag sticky", d, 32'h1);
      check("R8 tick irq masked", irq_tick, 0);
      // wrap
      wr(3'd2, 32'hFFFF_FFFE);
      for (int i = 0; i < 6; i++) pulse(1, 1);
      check("R5 wrapped count", count_o, 0);
      rd(3'd4, d); check("R5 ovf flag", d[2], 1);
      check("R5 ovf irq", irq_ovf, 1);
      // internal source: ext ignored
      wr(3'd0, 32'h1D);
      for (int i = 0; i < 6; i++) pulse(1, 0);
      check("R2 ext ignored", count_o, 0);
      for (int i = 0; i < 3; i++) pulse(0, 1);
      check("R2 int advances", count_o, 1);
      // fast divided source
      wr(3'd0, 32'h2D);
      wr(3'd1, 32'd0);
      expq.push_back(2); expq.push_back(3); expq.push_back(4);
      t = 0;
      while (expq.size() != 0 && t < 1000) begin @(negedge clk); t++; end
      wr(3'd0, 32'h0D);
      m_cnt = 4; m_reload = 0; m_pcnt = 0;
      checks++;
      if (t <= 256 || t > 390) begin
         failures++;
         $display("FAIL R2 fast divide actual=%0d expected=257..390", t);
      end
      // calibration output
      while (ext_total < 70) begin
         pulse(1, 1);
         if (ext_total % 8 == 0)
            check("R9 cal_o", cal_o, 32'((ext_total / 32) % 2));
      end
      repeat (3) @(negedge clk);
      check("R4 queue drained", expq.size(), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule